// File: doc/BRIEF.md
# Atomic Store-Add Memory Unit

This unit carries out an atomic add to one memory location and throws the fetched old value away. A command gives a byte address, a 64-bit addend and a size select. The size is either a 32-bit word or a 64-bit doubleword. The address goes to memory exactly as given, with no offset added. The unit reads the location, adds the addend, and writes the sum back. A lock line is held across the whole read-modify-write, so the memory side can keep every other requester out until the write completes.

In word mode only the low 32 bits of the addend take part, and the sum wraps at 32 bits. In doubleword mode the sum wraps at 64 bits. No overflow is reported, and nothing is returned to the issuer apart from a completion pulse.

A command whose address is not naturally aligned for its size is refused. The unit raises a one-cycle fault and makes no memory access. The command handshake is valid/ready. The read and write channels each use a request that is held until the matching acknowledge.

Top module: `amo_addstore_unit`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `fault`, `done`, `mem_lock`, `mem_rd_req` and `mem_wr_req` are all 0.
- R2: The read address and the write address both equal the accepted `cmd_addr` unchanged, with no offset added.
- R3: Word mode (`cmd_dword`=0): the written value is (memory word + `cmd_addend[31:0]`) mod 2^32. Word data travels in bits [31:0] of `mem_rd_data` and `mem_wr_data`. `mem_rd_data[63:32]` and `cmd_addend[63:32]` have no effect, and `mem_wr_data[63:32]` is 0.
- R4: Doubleword mode (`cmd_dword`=1): the written value is (memory doubleword + `cmd_addend`) mod 2^64.
- R5: A word command with `cmd_addr[1:0]`≠0, or a doubleword command with `cmd_addr[2:0]`≠0, makes `fault` high for exactly the one cycle after acceptance. No read or write request is issued for it.
- R6: `mem_lock` is high in every cycle from the first read-request cycle through the write-acknowledge cycle, and low at all other times.
- R7: `done` is high for exactly the one cycle after the cycle in which `mem_wr_ack` is sampled high with `mem_wr_req`.
- R8: `cmd_ready` is low from the cycle after acceptance until the unit is idle again. A command held valid during that time is accepted only once the unit is idle.
- R9: `mem_rd_size` and `mem_wr_size` equal the accepted `cmd_dword` (1 = doubleword).
- R10: Read and write requests are never high together. The write request starts only in the cycle after a read acknowledge. Requests are held through any number of wait cycles, and read data is taken only on the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, can accept a command |
| cmd_addr | input | AW | Byte address of the target location |
| cmd_addend | input | DW | Value to add (low half used in word mode) |
| cmd_dword | input | 1 | 1 = doubleword, 0 = word |
| mem_rd_req | output | 1 | Read request, held until acknowledged |
| mem_rd_addr | output | AW | Read byte address |
| mem_rd_size | output | 1 | Read size, 1 = doubleword |
| mem_rd_ack | input | 1 | Read acknowledge, data valid this cycle |
| mem_rd_data | input | DW | Read data (word in bits [31:0]) |
| mem_wr_req | output | 1 | Write request, held until acknowledged |
| mem_wr_addr | output | AW | Write byte address |
| mem_wr_size | output | 1 | Write size, 1 = doubleword |
| mem_wr_data | output | DW | Write data (word in bits [31:0]) |
| mem_wr_ack | input | 1 | Write acknowledge |
| mem_lock | output | 1 | Atomic lock over the read-modify-write |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle misalignment fault pulse |

## Verification
The hardest case to reach from the ports is a command offered while the unit is still busy. That includes the done cycle and the cycles spent waiting on a slow read or write acknowledge. The aim is to show that the command is neither taken early nor lost. The bench's memory responder inserts random wait cycles on both channels, and its command driver loads the next command with no gap about half the time, so valid stays high across the busy window. Directed commands cover the word-versus-doubleword misalignment boundary (address 4 is legal for a word but not for a doubleword), wrap-around in both sizes, and repeated adds to the same location.

// File: rtl/amo_pkg.sv
package amo_pkg;
  // One-hot sequencer state: each control output is a single flop bit.
  typedef enum logic [4:0] {
    ST_IDLE  = 5'b00001,
    ST_FAULT = 5'b00010,
    ST_READ  = 5'b00100,
    ST_WRITE = 5'b01000,
    ST_DONE  = 5'b10000
  } amo_state_e;
endpackage

// File: rtl/amo_align_chk.sv
module amo_align_chk #(
  parameter int DW = 64
) (
  input  logic [$clog2(DW/8)-1:0] addr_lo,
  input  logic                    dword,
  output logic                    misaligned
);
  localparam int DLSB = $clog2(DW/8);   // doubleword offset bits
  localparam int WLSB = $clog2(DW/16);  // word offset bits

  logic word_bad, dword_bad;
  assign word_bad   = |addr_lo[WLSB-1:0];
  assign dword_bad  = |addr_lo[DLSB-1:0];
  assign misaligned = dword ? dword_bad : word_bad;
endmodule

// File: rtl/amo_wrap_adder.sv
module amo_wrap_adder #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] addend,
  input  logic          dword,
  output logic [DW-1:0] sum
);
  localparam int HW = DW / 2;

  logic [HW:0]   lo_sum;
  logic [HW-1:0] hi_sum;

  // Low lane always used; the carry into the high lane only counts in
  // doubleword mode, and the high lane is forced to zero for words.
  assign lo_sum = {1'b0, old_val[HW-1:0]} + {1'b0, addend[HW-1:0]};
  assign hi_sum = old_val[DW-1:HW] + addend[DW-1:HW] + {{(HW-1){1'b0}}, lo_sum[HW]};
  assign sum    = {(dword ? hi_sum : {HW{1'b0}}), lo_sum[HW-1:0]};
endmodule

// File: rtl/amo_seq_ctrl.sv
module amo_seq_ctrl
  import amo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_valid,
  input  logic misaligned,
  input  logic rd_ack,
  input  logic wr_ack,
  output logic cmd_ready,
  output logic take_cmd,
  output logic take_sum,
  output logic rd_req,
  output logic wr_req,
  output logic lock,
  output logic done,
  output logic fault
);
  amo_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid) state_d = misaligned ? ST_FAULT : ST_READ;
      ST_FAULT: state_d = ST_IDLE;
      ST_READ:  if (rd_ack) state_d = ST_WRITE;
      ST_WRITE: if (wr_ack) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign cmd_ready = state_q[0];
  assign fault     = state_q[1];
  assign rd_req    = state_q[2];
  assign wr_req    = state_q[3];
  assign done      = state_q[4];
  assign lock      = state_q[2] | state_q[3];
  assign take_cmd  = state_q[0] & cmd_valid;
  assign take_sum  = state_q[2] & rd_ack;
endmodule

// File: rtl/amo_addstore_unit.sv
module amo_addstore_unit #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_addend,
  input  logic          cmd_dword,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  output logic          mem_rd_size,
  input  logic          mem_rd_ack,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_req,
  output logic [AW-1:0] mem_wr_addr,
  output logic          mem_wr_size,
  output logic [DW-1:0] mem_wr_data,
  input  logic          mem_wr_ack,
  output logic          mem_lock,
  output logic          done,
  output logic          fault
);
  localparam int OFS = $clog2(DW/8);

  logic          misaligned, take_cmd, take_sum;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] addend_q, sum_d, sum_q;
  logic          dword_q;

  amo_align_chk #(.DW(DW)) u_align (
    .addr_lo    (cmd_addr[OFS-1:0]),
    .dword      (cmd_dword),
    .misaligned (misaligned)
  );

  amo_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .misaligned (misaligned),
    .rd_ack     (mem_rd_ack),
    .wr_ack     (mem_wr_ack),
    .cmd_ready  (cmd_ready),
    .take_cmd   (take_cmd),
    .take_sum   (take_sum),
    .rd_req     (mem_rd_req),
    .wr_req     (mem_wr_req),
    .lock       (mem_lock),
    .done       (done),
    .fault      (fault)
  );

  amo_wrap_adder #(.DW(DW)) u_add (
    .old_val (mem_rd_data),
    .addend  (addend_q),
    .dword   (dword_q),
    .sum     (sum_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      addend_q <= '0;
      dword_q  <= 1'b0;
      sum_q    <= '0;
    end else begin
      if (take_cmd) begin
        addr_q   <= cmd_addr;
        addend_q <= cmd_addend;
        dword_q  <= cmd_dword;
      end
      if (take_sum) sum_q <= sum_d;
    end
  end

  assign mem_rd_addr = addr_q;
  assign mem_wr_addr = addr_q;
  assign mem_rd_size = dword_q;
  assign mem_wr_size = dword_q;
  assign mem_wr_data = sum_q;
endmodule

// File: rtl/amo_addstore_chk.sv
module amo_addstore_chk #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_ready,
  input logic             rd_req,
  input logic             rd_ack,
  input logic [AW-1:0]    rd_addr,
  input logic             rd_size,
  input logic             wr_req,
  input logic             wr_ack,
  input logic [AW-1:0]    wr_addr,
  input logic             wr_size,
  input logic [DW/2-1:0]  wr_data_hi,
  input logic             lock,
  input logic             done,
  input logic             fault
);
  AST_LOCK_COVERS_REQ: assert property (@(posedge clk) disable iff (rst)
    (rd_req || wr_req) |-> lock);  // R6
  AST_NO_STRAY_LOCK: assert property (@(posedge clk) disable iff (rst)
    lock |-> (rd_req || wr_req));  // R6
  AST_DONE_AFTER_WACK: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_ack) |=> done);  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R7
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!rd_req && !wr_req));  // R5
  AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fault |=> !fault);  // R5
  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
    (lock || done || fault) |-> !cmd_ready);  // R8
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));  // R10
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_req) |-> $past(rd_req && rd_ack));  // R10
  AST_RD_HELD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> rd_req);  // R10
  AST_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_req) |-> (wr_addr == $past(rd_addr)));  // R2
  AST_SAME_SIZE: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_req) |-> (wr_size == $past(rd_size)));  // R9
  AST_WORD_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_size) |-> (wr_data_hi == '0));  // R3
endmodule

bind amo_addstore_unit amo_addstore_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_ready  (cmd_ready),
  .rd_req     (mem_rd_req),
  .rd_ack     (mem_rd_ack),
  .rd_addr    (mem_rd_addr),
  .rd_size    (mem_rd_size),
  .wr_req     (mem_wr_req),
  .wr_ack     (mem_wr_ack),
  .wr_addr    (mem_wr_addr),
  .wr_size    (mem_wr_size),
  .wr_data_hi (mem_wr_data[DW-1:DW/2]),
  .lock       (mem_lock),
  .done       (done),
  .fault      (fault)
);

// File: tb/tb_amo_addstore_unit.sv
module tb_amo_addstore_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_addend = '0;
  logic          cmd_dword = 1'b0;
  logic          mem_rd_req, mem_rd_size, mem_wr_req, mem_wr_size;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic          mem_rd_ack = 1'b0;
  logic [DW-1:0] mem_rd_data = '0;
  logic [DW-1:0] mem_wr_data;
  logic          mem_wr_ack = 1'b0;
  logic          mem_lock, done, fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  amo_addstore_unit #(.AW(AW), .DW(DW)) dut (.*);

  int n_checks = 0;
  int n_fail   = 0;

  // Bench memory: doubleword storage keyed by address >> 3
  logic [63:0] mem_m [int unsigned];
  logic [31:0] q_addr[$];
  logic [63:0] q_add[$];
  logic        q_dw[$];

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_get(int unsigned k);
    if (mem_m.exists(k)) return mem_m[k];
    return {k * 32'h9E3779B9, ~k};
  endfunction

  task automatic push_op(logic [31:0] a, logic [63:0] v, logic dw);
    q_addr.push_back(a); q_add.push_back(v); q_dw.push_back(dw);
  endtask

  initial begin
    int phase = 0;        // 0 idle,1 fault,2 read,3 write,4 done
    int nxt;
    int rd_wait = 0, wr_wait = 0, gap = 0, cyc = 0;
    bit pend = 0;
    logic [31:0] c_addr = '0;
    logic [63:0] c_add = '0, exp_sum = '0, old = '0, w;
    logic        c_dw = 1'b0;
    logic [31:0] p_addr = '0;
    logic [63:0] p_add = '0;
    logic        p_dw = 1'b0;

    mem_m[32'h10 >> 3] = 64'h0000_0005_FFFF_FFFF;
    mem_m[32'h108 >> 3] = 64'hFFFF_FFFF_FFFF_FFFE;
    push_op(32'h10, 64'hDEAD_BEEF_0000_0001, 1'b0);   // R3 word wrap, upper addend ignored
    push_op(32'h14, 64'h1234_5678_0000_0010, 1'b0);   // R3 upper half of doubleword
    push_op(32'h108, 64'h3, 1'b1);                    // R4 doubleword wrap
    push_op(32'h102, 64'h1, 1'b0);                    // R5 misaligned word
    push_op(32'h104, 64'h1, 1'b1);                    // R5 word-aligned but bad doubleword
    push_op(32'h104, 64'h7, 1'b0);                    // R5 same address legal as word
    push_op(32'h10C, 64'h1, 1'b1);                    // R5
    push_op(32'h108, 64'h10, 1'b1);                   // R4 repeated add same location
    push_op(32'h108, 64'h10, 1'b1);
    for (int i = 0; i < 80; i++) begin
      logic [31:0] a;
      a = $urandom_range(0, 63);
      if ($urandom_range(0, 3) != 0) a = a & ~32'h3;
      push_op(a, {$urandom, $urandom}, 1'($urandom_range(0, 1)));
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "cmd_ready", 64'(cmd_ready), 64'd1);
    check("R1", "fault", 64'(fault), 64'd0);
    check("R1", "done", 64'(done), 64'd0);
    check("R1", "mem_lock", 64'(mem_lock), 64'd0);
    check("R1", "mem_rd_req", 64'(mem_rd_req), 64'd0);
    check("R1", "mem_wr_req", 64'(mem_wr_req), 64'd0);
    rst = 1'b0;

    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        break;
      end
      // Compare control outputs with the reference phase
      check("R8", "cmd_ready", 64'(cmd_ready), 64'(phase == 0));
      check("R5", "fault", 64'(fault), 64'(phase == 1));
      check("R10", "mem_rd_req", 64'(mem_rd_req), 64'(phase == 2));
      check("R10", "mem_wr_req", 64'(mem_wr_req), 64'(phase == 3));
      check("R6", "mem_lock", 64'(mem_lock), 64'(phase == 2 || phase == 3));
      check("R7", "done", 64'(done), 64'(phase == 4));
      if (phase == 2) begin
        check("R2", "mem_rd_addr", 64'(mem_rd_addr), 64'(c_addr));
        check("R9", "mem_rd_size", 64'(mem_rd_size), 64'(c_dw));
      end
      if (phase == 3) begin
        check("R2", "mem_wr_addr", 64'(mem_wr_addr), 64'(c_addr));
        check("R9", "mem_wr_size", 64'(mem_wr_size), 64'(c_dw));
        check(c_dw ? "R4" : "R3", "mem_wr_data", mem_wr_data, exp_sum);
      end

      if (phase == 0 && !pend && q_addr.size() == 0) break;

      // Command driver: may present the next command while busy (R8)
      if (!pend && q_addr.size() != 0) begin
        if (gap == 0) begin
          p_addr = q_addr.pop_front(); p_add = q_add.pop_front(); p_dw = q_dw.pop_front();
          pend = 1;
        end else gap--;
      end
      cmd_valid  = pend;
      cmd_addr   = p_addr;
      cmd_addend = p_add;
      cmd_dword  = p_dw;
      mem_rd_ack = 1'b0;
      mem_wr_ack = 1'b0;
      mem_rd_data = {$urandom, $urandom};
      nxt = phase;

      case (phase)
        0: if (pend) begin
          c_addr = p_addr; c_add = p_add; c_dw = p_dw;
          pend = 0;
          gap = $urandom_range(0, 1) == 0 ? 0 : $urandom_range(1, 3);
          nxt = (c_dw ? (c_addr[2:0] != 0) : (c_addr[1:0] != 0)) ? 1 : 2;
          rd_wait = $urandom_range(0, 3);
        end
        2: if (rd_wait == 0) begin
          w = mem_get(c_addr >> 3);
          old = c_dw ? w : {32'h0, (c_addr[2] ? w[63:32] : w[31:0])};
          mem_rd_ack  = 1'b1;
          mem_rd_data = c_dw ? old : {$urandom, old[31:0]};
          exp_sum = c_dw ? old + c_add : {32'h0, old[31:0] + c_add[31:0]};
          wr_wait = $urandom_range(0, 3);
          nxt = 3;
        end else rd_wait--;
        3: if (wr_wait == 0) begin
          mem_wr_ack = 1'b1;
          w = mem_get(c_addr >> 3);
          if (c_dw) w = exp_sum;
          else if (c_addr[2]) w[63:32] = exp_sum[31:0];
          else w[31:0] = exp_sum[31:0];
          mem_m[c_addr >> 3] = w;
          nxt = 4;
        end else wr_wait--;
        default: nxt = 0;
      endcase
      phase = nxt;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule